// File: doc/BRIEF.md
# Half-Duplex Ethernet Nibble Transmitter

This block sequences one frame at a time onto a 4-bit transmit path, one nibble per clock, for a shared half-duplex Ethernet segment. It waits for the medium to go quiet and holds off for the inter-frame gap. It then sends the preamble and start delimiter and streams the payload bytes, low nibble first. If the frame is short it can append zero padding, and it can close the frame with a computed frame check sequence.

A byte source supplies `tx_byte` and marks the final byte with `tx_last`. It advances to the next byte on every cycle in which `byte_next` is high. When a collision is sensed, the block sends a jam pattern and hands control to an external backoff timer through `bo_start`. It then waits for `bo_expired` and retries the frame from the preamble. After too many collisions it drops the frame and reports an abort.

Top module: `hdx_tx_mac`

## Requirements
- R1: While `rst_n` is low, and after its release while `crs` stays high, `mii_txen` is 0, `mii_txd` is 0, and `tx_done`, `tx_abort` and `bo_start` are 0.
- R2: With `tx_req` held high, `mii_txen` first reads high at the 26th falling clock edge after `crs` falls (one deferral cycle, a 24-cycle gap, one idle cycle). If `crs` rises again during the gap or idle cycle, the count restarts from its next fall.
- R3: A frame opens with 15 nibbles of 0x5 followed by one nibble 0xD, with `mii_txen` high.
- R4: Each byte is sent as `tx_byte[3:0]` followed by `tx_byte[7:4]`. `byte_next` is high for exactly one cycle per byte, during the high nibble. The byte with `tx_last` high is the final payload byte.
- R5: When `pad_en` is 1 and the payload is shorter than 60 bytes, zero nibbles follow the payload until 60 bytes have been sent. When `pad_en` is 0, no padding is added.
- R6: When `crc_en` is 1, eight nibbles follow the payload and padding. They carry the complemented CRC-32 over those bytes, computed bit-serially LSB first with the reflected polynomial 0xEDB88320 and a start value of all ones, least significant nibble first. When `crc_en` is 0, no check nibbles are sent.
- R7: If `col` is high at a clock edge while preamble, data, pad or check nibbles are being sent, the next 8 nibbles are 0x9 with `mii_txen` high.
- R8: `bo_start` is high during the last jam nibble. Afterwards, `bo_expired` or `crs` ends the backoff wait and returns the machine to deferral. The retry resends the whole frame from the preamble.
- R9: On the 16th collision of one frame, `tx_abort` is high during the last jam nibble instead of `bo_start`, and the frame is dropped. The collision count restarts for the next frame.
- R10: One cycle after the last nibble of a frame, `tx_done` is high for one cycle with `mii_txen` low. `mii_txen` is low in every cycle outside preamble, data, pad, check and jam nibbles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tx_req | input | 1 | A frame is ready to send |
| tx_byte | input | 8 | Current payload byte |
| tx_last | input | 1 | Current byte is the final payload byte |
| pad_en | input | 1 | Pad short frames with zeros |
| crc_en | input | 1 | Append the 32-bit check sequence |
| crs | input | 1 | Carrier sensed on the medium |
| col | input | 1 | Collision sensed on the medium |
| bo_expired | input | 1 | External backoff wait has elapsed |
| mii_txd | output | 4 | Transmit nibble |
| mii_txen | output | 1 | Transmit enable |
| byte_next | output | 1 | Advance to the next payload byte |
| tx_done | output | 1 | Frame sent, one-cycle pulse |
| tx_abort | output | 1 | Frame dropped after too many collisions, one-cycle pulse |
| bo_start | output | 1 | Start the backoff timer (retry pending), one-cycle pulse |

## Verification
`mii_txd` and `mii_txen` are decoded from the state register. A nibble therefore appears in the cycle after the edge that enters its state, and the bench reads every output at the falling edge of the clock. A collision raised at one falling edge is seen at the next rising edge, so the jam nibbles start at the sample after that. `bo_start` and `tx_abort` read high at the same sample as the eighth jam nibble, and `tx_done` one sample after the last nibble. The gap check counts falling edges from the fall of `crs` and expects transmit enable at exactly the 26th.

// File: rtl/hdx_tx_pkg.sv
`timescale 1ns/1ps
// Shared types for the half-duplex transmitter.
// Assumes: one state per nibble slot of the transmit sequence.
package hdx_tx_pkg;
    typedef enum logic [3:0] {
        ST_DEFER   = 4'd0,
        ST_IFG     = 4'd1,
        ST_IDLE    = 4'd2,
        ST_PRE     = 4'd3,
        ST_DAT0    = 4'd4,
        ST_DAT1    = 4'd5,
        ST_PAD     = 4'd6,
        ST_FCS     = 4'd7,
        ST_JAM     = 4'd8,
        ST_BACKOFF = 4'd9,
        ST_DONE    = 4'd10
    } tx_state_t;

    localparam logic [3:0] NIB_PRE  = 4'h5;
    localparam logic [3:0] NIB_SFD  = 4'hD;
    localparam logic [3:0] NIB_JAM  = 4'h9;
endpackage

// File: rtl/hdx_sat_counter.sv
`timescale 1ns/1ps
// Up counter that holds at its all-ones value.
// Assumes: clear has priority over enable; synchronous active-low reset.
module hdx_sat_counter #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = {W{1'b1}};

    // Count enabled cycles since the last clear, saturating at TOP.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (en && cnt != TOP)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/hdx_crc_nib.sv
`timescale 1ns/1ps
// Nibble-serial CRC-32 in reflected form (LSB of each nibble first).
// Holds the running remainder while feeding and then shifts it out as
// complemented nibbles, lowest nibble first.
// Assumes: init, feed and shift are never needed in the same cycle.
module hdx_crc_nib #(
    parameter logic [31:0] POLY = 32'hEDB88320
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       init,
    input  logic       feed,
    input  logic       shift,
    input  logic [3:0] nib_in,
    output logic [3:0] fcs_nib
);
    logic [31:0] rem_q;

    function automatic logic [31:0] step4(input logic [31:0] c, input logic [3:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 4; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ POLY;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // Update the remainder: preset, absorb a nibble, or shift out a nibble.
    always_ff @(posedge clk) begin
        if (!rst_n || init)
            rem_q <= '1;
        else if (feed)
            rem_q <= step4(rem_q, nib_in);
        else if (shift)
            rem_q <= {4'hF, rem_q[31:4]};
    end

    assign fcs_nib = ~rem_q[3:0];
endmodule

// File: rtl/hdx_tx_mac.sv
`timescale 1ns/1ps
// Half-duplex transmit sequencer, one nibble per clock.
// Defers to carrier, waits the inter-frame gap, sends preamble/SFD,
// payload nibbles, optional zero pad and check sequence. A collision
// diverts to jam, then backoff (external timer), then deferral.
// Assumes: tx_byte/tx_last valid whenever data states need them;
// the byte source advances on each cycle with byte_next high.
module hdx_tx_mac
    import hdx_tx_pkg::*;
#(
    parameter int IFG_NIB   = 24,
    parameter int PRE_NIB   = 15,
    parameter int JAM_NIB   = 8,
    parameter int FCS_NIB   = 8,
    parameter int MIN_DATA  = 60,
    parameter int MAX_TRIES = 16,
    parameter int FN_W      = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_req,
    input  logic [7:0] tx_byte,
    input  logic       tx_last,
    input  logic       pad_en,
    input  logic       crc_en,
    input  logic       crs,
    input  logic       col,
    input  logic       bo_expired,
    output logic [3:0] mii_txd,
    output logic       mii_txen,
    output logic       byte_next,
    output logic       tx_done,
    output logic       tx_abort,
    output logic       bo_start
);
    localparam int SC_A   = (IFG_NIB > PRE_NIB + 1) ? IFG_NIB : PRE_NIB + 1;
    localparam int SC_B   = (JAM_NIB > FCS_NIB) ? JAM_NIB : FCS_NIB;
    localparam int SC_TOP = (SC_A > SC_B) ? SC_A : SC_B;
    localparam int SC_W   = $clog2(SC_TOP + 1);
    localparam int AT_W   = $clog2(MAX_TRIES + 1);

    localparam logic [SC_W-1:0] SC_IFG_END = SC_W'(IFG_NIB - 1);
    localparam logic [SC_W-1:0] SC_SFD     = SC_W'(PRE_NIB);
    localparam logic [SC_W-1:0] SC_JAM_END = SC_W'(JAM_NIB - 1);
    localparam logic [SC_W-1:0] SC_FCS_END = SC_W'(FCS_NIB - 1);
    localparam logic [FN_W-1:0] FN_PAD_END = FN_W'(2 * MIN_DATA - 1);
    localparam logic [AT_W-1:0] AT_LIMIT   = AT_W'(MAX_TRIES);

    tx_state_t       state_q, state_d;
    logic [SC_W-1:0] slot_cnt;
    logic [FN_W-1:0] nib_cnt;
    logic [AT_W-1:0] try_cnt;
    logic            sending, jam_end, give_up;
    logic [3:0]      fcs_nib;

    assign sending = (state_q == ST_PRE) || (state_q == ST_DAT0) || (state_q == ST_DAT1)
                  || (state_q == ST_PAD) || (state_q == ST_FCS);
    assign jam_end = (state_q == ST_JAM) && (slot_cnt == SC_JAM_END);
    assign give_up = jam_end && (try_cnt == AT_LIMIT);

    // Next-state choice; a collision while sending overrides everything.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_DEFER:   if (!crs) state_d = ST_IFG;
            ST_IFG:     if (crs) state_d = ST_DEFER;
                        else if (slot_cnt == SC_IFG_END) state_d = ST_IDLE;
            ST_IDLE:    if (crs) state_d = ST_DEFER;
                        else if (tx_req) state_d = ST_PRE;
            ST_PRE:     if (slot_cnt == SC_SFD) state_d = ST_DAT0;
            ST_DAT0:    state_d = ST_DAT1;
            ST_DAT1:    if (!tx_last) state_d = ST_DAT0;
                        else if (pad_en && nib_cnt < FN_PAD_END) state_d = ST_PAD;
                        else if (crc_en) state_d = ST_FCS;
                        else state_d = ST_DONE;
            ST_PAD:     if (nib_cnt == FN_PAD_END) state_d = crc_en ? ST_FCS : ST_DONE;
            ST_FCS:     if (slot_cnt == SC_FCS_END) state_d = ST_DONE;
            ST_JAM:     if (give_up) state_d = ST_DEFER;
                        else if (jam_end) state_d = ST_BACKOFF;
            ST_BACKOFF: if (bo_expired || crs) state_d = ST_DEFER;
            ST_DONE:    state_d = ST_DEFER;
            default:    state_d = ST_DEFER;
        endcase
        if (sending && col) state_d = ST_JAM;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_DEFER;
        else        state_q <= state_d;
    end

    // Cycles spent in the current state.
    hdx_sat_counter #(.W(SC_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .clr(state_d != state_q), .en(1'b1), .cnt(slot_cnt)
    );

    // Payload-plus-pad nibbles sent in this attempt.
    hdx_sat_counter #(.W(FN_W)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .clr(state_q == ST_PRE),
        .en((state_q == ST_DAT0) || (state_q == ST_DAT1) || (state_q == ST_PAD)),
        .cnt(nib_cnt)
    );

    // Collisions seen for the current frame.
    hdx_sat_counter #(.W(AT_W)) u_tries (
        .clk(clk), .rst_n(rst_n),
        .clr((state_q == ST_DONE) || give_up),
        .en((state_d == ST_JAM) && (state_q != ST_JAM)),
        .cnt(try_cnt)
    );

    // Running check sequence over payload and pad nibbles.
    hdx_crc_nib u_crc (
        .clk(clk), .rst_n(rst_n),
        .init(state_q == ST_PRE),
        .feed((state_q == ST_DAT0) || (state_q == ST_DAT1) || (state_q == ST_PAD)),
        .shift(state_q == ST_FCS),
        .nib_in(mii_txd),
        .fcs_nib(fcs_nib)
    );

    // Nibble selection by state.
    always_comb begin
        unique case (state_q)
            ST_PRE:  mii_txd = (slot_cnt == SC_SFD) ? NIB_SFD : NIB_PRE;
            ST_DAT0: mii_txd = tx_byte[3:0];
            ST_DAT1: mii_txd = tx_byte[7:4];
            ST_FCS:  mii_txd = fcs_nib;
            ST_JAM:  mii_txd = NIB_JAM;
            default: mii_txd = 4'h0;
        endcase
    end

    assign mii_txen  = sending || (state_q == ST_JAM);
    assign byte_next = (state_q == ST_DAT1) && !col;
    assign tx_done   = (state_q == ST_DONE);
    assign tx_abort  = give_up;
    assign bo_start  = jam_end && !give_up;
endmodule

// File: rtl/hdx_tx_mac_chk.sv
`timescale 1ns/1ps
// Protocol checker for hdx_tx_mac, attached by bind.
// Assumes: state is the sequencer's registered state.
module hdx_tx_mac_chk
    import hdx_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_req,
    input  logic       crs,
    input  logic       col,
    input  logic [3:0] mii_txd,
    input  logic       mii_txen,
    input  logic       byte_next,
    input  logic       tx_done,
    input  logic       tx_abort,
    input  logic       bo_start,
    input  tx_state_t  state
);
    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> !mii_txen); // R1
    AST_IDLE_START:  assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !crs && tx_req) |=> (mii_txen && mii_txd == 4'h5)); // R2
    AST_NEXT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        byte_next |=> !byte_next); // R4
    AST_COL_JAM:     assert property (@(posedge clk) disable iff (!rst_n)
        (mii_txen && col && state != ST_JAM) |=> (mii_txen && mii_txd == 4'h9)); // R7
    AST_BO_CRS:      assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BACKOFF && crs) |=> (state == ST_DEFER)); // R8
    AST_PULSE_EXCL:  assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_done, tx_abort, bo_start})); // R9
    AST_DONE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> !mii_txen); // R10
endmodule

bind hdx_tx_mac hdx_tx_mac_chk u_chk (
    .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .crs(crs), .col(col),
    .mii_txd(mii_txd), .mii_txen(mii_txen), .byte_next(byte_next),
    .tx_done(tx_done), .tx_abort(tx_abort), .bo_start(bo_start),
    .state(state_q)
);

// File: tb/hdx_tx_mac_test.sv
`timescale 1ns/1ps
// Directed bench for hdx_tx_mac; outputs sampled at falling edges.
module hdx_tx_mac_test;
    logic       clk = 1'b0;
    logic       rst_n, tx_req, tx_last, pad_en, crc_en, crs, col, bo_expired;
    logic [7:0] tx_byte;
    logic [3:0] mii_txd;
    logic       mii_txen, byte_next, tx_done, tx_abort, bo_start;

    always #5 clk = ~clk;

    hdx_tx_mac uut (
        .clk(clk), .rst_n(rst_n), .tx_req(tx_req), .tx_byte(tx_byte),
        .tx_last(tx_last), .pad_en(pad_en), .crc_en(crc_en), .crs(crs),
        .col(col), .bo_expired(bo_expired), .mii_txd(mii_txd),
        .mii_txen(mii_txen), .byte_next(byte_next), .tx_done(tx_done),
        .tx_abort(tx_abort), .bo_start(bo_start)
    );

    // Byte source: rewinds whenever the transmitter is not driving.
    logic [7:0] fbytes [0:127];
    int flen = 1;
    int idx  = 0;
    always @(posedge clk) begin
        if (!mii_txen)                  idx <= 0;
        else if (byte_next && idx < 127) idx <= idx + 1;
    end
    assign tx_byte = fbytes[idx[6:0]];
    assign tx_last = (idx == flen - 1);

    int nvec = 0, nerr = 0;
    bit finished = 0;
    logic [3:0] cap  [0:399];
    logic [3:0] expn [0:399];
    int ncap, nexp, endby, nbn;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic load_frame(input int len, input int seed);
        for (int i = 0; i < 128; i++) fbytes[i] = (i < len) ? 8'(i * 13 + seed) : 8'h00;
        flen = len;
    endtask

    // Expected nibble stream from the requirements.
    task automatic build_expect(input int len, input bit pad, input bit crc);
        logic [31:0] c;
        logic [7:0]  b;
        int total;
        nexp = 0;
        c = 32'hFFFF_FFFF;
        for (int i = 0; i < 15; i++) begin expn[nexp] = 4'h5; nexp++; end
        expn[nexp] = 4'hD; nexp++;
        total = (pad && len < 60) ? 60 : len;
        for (int i = 0; i < total; i++) begin
            b = (i < len) ? fbytes[i] : 8'h00;
            expn[nexp] = b[3:0]; nexp++;
            expn[nexp] = b[7:4]; nexp++;
            for (int k = 0; k < 8; k++) begin
                if (c[0] ^ b[k]) c = (c >> 1) ^ 32'hEDB88320;
                else             c = c >> 1;
            end
        end
        if (crc) begin
            c = ~c;
            for (int k = 0; k < 8; k++) begin expn[nexp] = c[4*k +: 4]; nexp++; end
        end
    endtask

    // Record driven nibbles until done, backoff start or abort.
    task automatic capture(input int col_at);
        bit hit;
        hit = 0; ncap = 0; endby = 0; nbn = 0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            if (mii_txen) begin
                if (ncap < 400) cap[ncap] = mii_txd;
                ncap++;
            end
            if (byte_next) nbn++;
            col = 1'b0;
            if (col_at >= 0 && !hit && mii_txen && ncap - 1 == col_at) begin
                col = 1'b1; hit = 1;
            end
            if (tx_done)  begin endby = 1; break; end
            if (bo_start) begin endby = 2; break; end
            if (tx_abort) begin endby = 3; break; end
        end
        col = 1'b0;
    endtask

    task automatic cmp_stream(input string tag, input int upto);
        int bad;
        bad = -1;
        for (int i = 0; i < upto && i < 400; i++)
            if (cap[i] !== expn[i] && bad < 0) bad = i;
        chk(bad < 0, tag, (bad < 0) ? 0 : int'(cap[bad]), (bad < 0) ? 0 : int'(expn[bad]));
    endtask

    task automatic pulse_expired();
        bo_expired = 1'b1;
        @(negedge clk); @(negedge clk);
        bo_expired = 1'b0;
    endtask

    task automatic count_to_txen(output int n);
        n = 0;
        for (int i = 1; i <= 200; i++) begin
            @(negedge clk);
            if (mii_txen) begin n = i; break; end
        end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 4000; i++) begin
            @(negedge clk);
            if (tx_done) break;
        end
        tx_req = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; tx_req = 1'b0; pad_en = 1'b0; crc_en = 1'b0;
        crs = 1'b1; col = 1'b0; bo_expired = 1'b0;
        repeat (3) @(negedge clk);
        chk(!mii_txen && mii_txd == 4'h0, "R1 reset quiet", int'(mii_txen), 0);
        chk(!tx_done && !tx_abort && !bo_start, "R1 reset pulses", int'(tx_done), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(!mii_txen, "R1 defer under carrier", int'(mii_txen), 0);
    endtask

    task automatic t_gap();
        int n;
        load_frame(8, 3); pad_en = 1'b0; crc_en = 1'b0;
        tx_req = 1'b1;
        repeat (5) @(negedge clk);
        chk(!mii_txen, "R2 request held under carrier", int'(mii_txen), 0);
        crs = 1'b0;
        count_to_txen(n);
        chk(n == 26, "R2 gap length", n, 26);
        wait_done();
        tx_req = 1'b1;
        repeat (10) @(negedge clk);
        crs = 1'b1;
        @(negedge clk);
        crs = 1'b0;
        count_to_txen(n);
        chk(n == 26, "R2 gap restart", n, 26);
        wait_done();
    endtask

    task automatic t_frame(input int len, input bit pad, input bit crc, input string tag);
        load_frame(len, len);
        pad_en = pad; crc_en = crc;
        tx_req = 1'b1;
        capture(-1);
        tx_req = 1'b0;
        build_expect(len, pad, crc);
        chk(endby == 1, {tag, " R10 done"}, endby, 1);
        chk(!mii_txen, "R10 txen low at done", int'(mii_txen), 0);
        chk(ncap == nexp, {tag, " nibble count"}, ncap, nexp);
        cmp_stream({tag, " stream"}, nexp);
        chk(nbn == len, "R4 byte_next count", nbn, len);
    endtask

    task automatic t_collision();
        load_frame(20, 7); pad_en = 1'b1; crc_en = 1'b1;
        tx_req = 1'b1;
        capture(40);
        build_expect(20, 1'b1, 1'b1);
        chk(endby == 2, "R8 bo_start at jam end", endby, 2);
        chk(ncap == 49, "R7 jam length", ncap, 49);
        cmp_stream("R7 before collision", 41);
        for (int i = 41; i < 49; i++) expn[i] = 4'h9;
        cmp_stream("R7 jam nibbles", 49);
        pulse_expired();
        capture(-1);
        tx_req = 1'b0;
        build_expect(20, 1'b1, 1'b1);
        chk(endby == 1 && ncap == nexp, "R8 retry complete", ncap, nexp);
        cmp_stream("R8 retry stream", nexp);
    endtask

    task automatic t_bo_crs();
        int n;
        load_frame(30, 1); pad_en = 1'b0; crc_en = 1'b1;
        tx_req = 1'b1;
        capture(25);
        chk(endby == 2, "R8 backoff entered", endby, 2);
        crs = 1'b1;
        repeat (6) @(negedge clk);
        chk(!mii_txen, "R8 quiet under carrier", int'(mii_txen), 0);
        crs = 1'b0;
        count_to_txen(n);
        chk(n == 26, "R8 carrier ends backoff", n, 26);
        wait_done();
    endtask

    task automatic t_abort();
        int nbo, last;
        bit seen_tx;
        load_frame(16, 5); pad_en = 1'b0; crc_en = 1'b1;
        tx_req = 1'b1;
        nbo = 0; last = -1;
        for (int a = 0; a < 16; a++) begin
            capture(20);
            last = a;
            if (endby == 2) begin nbo++; pulse_expired(); end
            else break;
        end
        tx_req = 1'b0;
        chk(nbo == 15, "R9 backoffs before abort", nbo, 15);
        chk(endby == 3 && last == 15, "R9 abort on 16th", endby, 3);
        seen_tx = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (mii_txen) seen_tx = 1;
        end
        chk(!seen_tx, "R9 frame dropped", int'(seen_tx), 0);
        tx_req = 1'b1;
        capture(20);
        chk(endby == 2, "R9 count restarts", endby, 2);
        pulse_expired();
        capture(-1);
        tx_req = 1'b0;
        chk(endby == 1, "R9 next frame done", endby, 1);
    endtask

    initial begin
        t_reset();
        t_gap();
        crs = 1'b0;
        t_frame(64, 1'b1, 1'b1, "R3 R4 R6 long");
        t_frame(10, 1'b1, 1'b1, "R5 R6 padded");
        t_frame(10, 1'b0, 1'b1, "R5 no pad");
        t_frame(12, 1'b0, 1'b0, "R6 no crc");
        t_frame(7, 1'b1, 1'b0, "R5 pad no crc");
        t_collision();
        t_bo_crs();
        t_abort();
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        #1_900_000;
        if (!finished) begin
            nvec++; nerr++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule